// File: doc/BRIEF.md
# Write-Once System Options Register

This block holds an 8-bit system options byte on a simple bus port: a write strobe with a data byte, and a read bus that always shows the current contents. Three fields are protected against stray writes. These are the security level, the stop-mode enable and the 2-bit watchdog timeout select. They take their value from the first bus write after reset and then hold it until the next reset. The wait-mode enable is not protected and follows every bus write.

The decoded fields drive three consumers. The first is a combinational off-chip access filter that permits or blocks each access, depending on an external security-enabled flag and on whether the access is an opcode fetch or a data access. The second is a low-power instruction checker. It grants stop or wait attempts whose enable bit is set. When neither mode is enabled, it raises a one-cycle illegal-opcode reset request for a stop attempt, unless an external disable flag holds that request back. The third is the timeout select, passed straight through to an external watchdog.

Top module: `sysopt_lockreg`

## Requirements
- R1: After reset the read bus shows 0x1C: security level (bit 6) 0, stop enable (bit 5) 0, wait enable (bit 4) 1, timeout select (bits 3:2) 11. The protection lock is open.
- R2: The first bus write after reset loads bit 6 (security level), bit 5 (stop enable) and bits 3:2 (timeout select) from the write data, and the new value is visible on the read bus one cycle later.
- R3: Every bus write after the first leaves bits 6, 5 and 3:2 unchanged. A new reset opens the lock again, so the next write is once more accepted.
- R4: Bit 4 (wait enable) takes the written value on every bus write, locked or not.
- R5: Bits 7, 1 and 0 always read as zero, whatever has been written.
- R6: While the security flag input is low, the access filter permits every access, fetch or data, whatever the security level bit holds.
- R7: While the security flag is high and the security level bit is 0, the access filter blocks both opcode fetches and data accesses.
- R8: While the security flag is high and the security level bit is 1, opcode fetches are blocked and data accesses are permitted.
- R9: A stop attempt with stop enable set, or a wait attempt with wait enable set, raises the mode grant in the cycle after the attempt. An attempt whose enable bit is clear gives no grant.
- R10: A stop attempt made while stop enable and wait enable are both 0 and the disable input is low raises the illegal-opcode reset request for exactly one cycle after the attempt, even when the attempt is held for several cycles. With the disable input high, no request is raised.
- R11: The watchdog select output always equals bits 3:2 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Current register contents |
| sec_on | input | 1 | Security enabled flag |
| acc_is_fetch | input | 1 | Current off-chip access is an opcode fetch (1) or data (0) |
| acc_ok | output | 1 | Off-chip access permitted |
| ill_rst_dis | input | 1 | Suppress the illegal-opcode reset request |
| stop_try | input | 1 | Stop instruction attempted this cycle |
| wait_try | input | 1 | Wait instruction attempted this cycle |
| mode_grant | output | 1 | Low-power mode entry granted |
| ill_rst_req | output | 1 | Illegal-opcode reset request pulse |
| wdog_sel | output | 2 | Watchdog timeout select |

## Verification
The illegal-opcode path is the hardest state to reach. It needs both stop and wait enable at 0, but reset leaves wait enable at 1 and stop enable can only be changed by the single unlocked write. The stimulus therefore resets, spends the one accepted write on a value with both enables clear, and only then makes stop attempts: single-cycle, held over several cycles, and with the disable input high. Each access-filter case also needs its own reset, because the security level can be set only once per reset. The table loop resets before each vector for this reason.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;

  localparam int TSEL_W   = 2;
  localparam int BYTE_W   = 8;
  localparam int POS_SL   = 6;
  localparam int POS_STOP = 5;
  localparam int POS_WAIT = 4;
  localparam int POS_TSEL = 2;
  localparam logic [BYTE_W-1:0] OPT_RST = 8'h1C;

  typedef struct packed {
    logic              sl;
    logic              stope;
    logic              waite;
    logic [TSEL_W-1:0] tsel;
  } opt_t;

  function automatic opt_t opt_from_byte(input logic [BYTE_W-1:0] b);
    opt_t o;
    o.sl    = b[POS_SL];
    o.stope = b[POS_STOP];
    o.waite = b[POS_WAIT];
    o.tsel  = b[POS_TSEL +: TSEL_W];
    return o;
  endfunction

  function automatic logic [BYTE_W-1:0] opt_to_byte(input opt_t o);
    logic [BYTE_W-1:0] b;
    b                      = '0;
    b[POS_SL]              = o.sl;
    b[POS_STOP]            = o.stope;
    b[POS_WAIT]            = o.waite;
    b[POS_TSEL +: TSEL_W]  = o.tsel;
    return b;
  endfunction

  function automatic logic offchip_allowed(input logic sec, input logic sl,
                                           input logic fetch);
    if (!sec)       return 1'b1;
    else if (fetch) return 1'b0;
    else            return sl;
  endfunction

endpackage

// File: rtl/sysopt_regfile.sv
module sysopt_regfile
  import sysopt_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_VAL = OPT_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output opt_t              opts,
  output logic              locked,
  output logic              open_wr
);

  localparam opt_t RST_OPTS = opt_from_byte(RESET_VAL);

  opt_t opts_q;
  opt_t wr_opts;
  logic lock_q;
  logic unused_wr_bits;

  assign wr_opts        = opt_from_byte(wr_data);
  assign unused_wr_bits = ^{wr_data[BYTE_W-1], wr_data[POS_TSEL-1:0]};
  assign open_wr        = wr_en && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opts_q <= RST_OPTS;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      opts_q.waite <= wr_opts.waite;
      lock_q       <= 1'b1;
      if (!lock_q) begin
        opts_q.sl    <= wr_opts.sl;
        opts_q.stope <= wr_opts.stope;
        opts_q.tsel  <= wr_opts.tsel;
      end
    end
  end

  assign opts   = opts_q;
  assign locked = lock_q;

endmodule

// File: rtl/sysopt_gate.sv
module sysopt_gate
  import sysopt_pkg::*;
(
  input  logic sec_on,
  input  logic sl,
  input  logic acc_is_fetch,
  output logic acc_ok
);

  assign acc_ok = offchip_allowed(sec_on, sl, acc_is_fetch);

endmodule

// File: rtl/sysopt_mode.sv
module sysopt_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic stope,
  input  logic waite,
  input  logic ill_rst_dis,
  input  logic stop_try,
  input  logic wait_try,
  output logic mode_grant,
  output logic ill_rst_req
);

  logic grant_now;
  logic ill_now;
  logic ill_prev;

  assign grant_now = (stop_try && stope) || (wait_try && waite);
  assign ill_now   = stop_try && !stope && !waite && !ill_rst_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_grant  <= 1'b0;
      ill_rst_req <= 1'b0;
      ill_prev    <= 1'b0;
    end else begin
      mode_grant  <= grant_now;
      ill_rst_req <= ill_now && !ill_prev;
      ill_prev    <= ill_now;
    end
  end

endmodule

// File: rtl/sysopt_lockreg.sv
module sysopt_lockreg
  import sysopt_pkg::*;
#(
  parameter logic [7:0] RESET_VAL = OPT_RST
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sec_on,
  input  logic       acc_is_fetch,
  output logic       acc_ok,
  input  logic       ill_rst_dis,
  input  logic       stop_try,
  input  logic       wait_try,
  output logic       mode_grant,
  output logic       ill_rst_req,
  output logic [1:0] wdog_sel
);

  opt_t opts;
  logic opt_locked;
  logic first_wr;

  sysopt_regfile #(.RESET_VAL(RESET_VAL)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .opts    (opts),
    .locked  (opt_locked),
    .open_wr (first_wr)
  );

  sysopt_gate i_gate (
    .sec_on       (sec_on),
    .sl           (opts.sl),
    .acc_is_fetch (acc_is_fetch),
    .acc_ok       (acc_ok)
  );

  sysopt_mode i_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .stope       (opts.stope),
    .waite       (opts.waite),
    .ill_rst_dis (ill_rst_dis),
    .stop_try    (stop_try),
    .wait_try    (wait_try),
    .mode_grant  (mode_grant),
    .ill_rst_req (ill_rst_req)
  );

  assign rd_data  = opt_to_byte(opts);
  assign wdog_sel = opts.tsel;

endmodule

// File: rtl/sysopt_chk.sv
module sysopt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sec_on,
  input logic       acc_is_fetch,
  input logic       acc_ok,
  input logic       mode_grant,
  input logic       ill_rst_req,
  input logic [1:0] wdog_sel,
  input logic       opt_locked,
  input logic       first_wr
);

  AST_FIRST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    first_wr |=> (rd_data[6:5] == $past(wr_data[6:5]) && rd_data[3:2] == $past(wr_data[3:2]))); // R2

  AST_LOCKED_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && opt_locked) |=> (rd_data[6:5] == $past(rd_data[6:5]) && rd_data[3:2] == $past(rd_data[3:2]))); // R3

  AST_WAIT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[4] == $past(wr_data[4])); // R4

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == 1'b0 && rd_data[1:0] == 2'b00); // R5

  AST_OPEN_WHEN_INSECURE: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_on |-> acc_ok); // R6

  AST_FETCH_BLOCKED_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_on && acc_is_fetch) |-> !acc_ok); // R7

  AST_DATA_BY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_on && !acc_is_fetch) |-> (acc_ok == rd_data[6])); // R8

  AST_ILL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ill_rst_req |=> !ill_rst_req); // R10

  AST_GRANT_NOT_ILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_grant && ill_rst_req)); // R10

  AST_WDOG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_sel == rd_data[3:2]); // R11

endmodule

bind sysopt_lockreg sysopt_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .sec_on       (sec_on),
  .acc_is_fetch (acc_is_fetch),
  .acc_ok       (acc_ok),
  .mode_grant   (mode_grant),
  .ill_rst_req  (ill_rst_req),
  .wdog_sel     (wdog_sel),
  .opt_locked   (opt_locked),
  .first_wr     (first_wr)
);

// File: tb/test_sysopt_lockreg.sv
`timescale 1ns/100ps
module test_sysopt_lockreg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sec_on = 1'b0;
  logic       acc_is_fetch = 1'b0;
  logic       acc_ok;
  logic       ill_rst_dis = 1'b0;
  logic       stop_try = 1'b0;
  logic       wait_try = 1'b0;
  logic       mode_grant;
  logic       ill_rst_req;
  logic [1:0] wdog_sel;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sysopt_lockreg i_sysopt_lockreg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sec_on(sec_on), .acc_is_fetch(acc_is_fetch), .acc_ok(acc_ok),
    .ill_rst_dis(ill_rst_dis), .stop_try(stop_try), .wait_try(wait_try),
    .mode_grant(mode_grant), .ill_rst_req(ill_rst_req), .wdog_sel(wdog_sel)
  );

  // {sec_on, security level, fetch, expected acc_ok}
  localparam logic [3:0] FILT_TAB [8] = '{
    4'b0001, 4'b0011, 4'b0101, 4'b0111,
    4'b1000, 4'b1010, 4'b1101, 4'b1110
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one-cycle attempt; returns outputs seen in the cycle after it
  task automatic attempt(input logic is_stop, output logic g, output logic ill);
    @(negedge clk);
    stop_try = is_stop;
    wait_try = !is_stop;
    @(negedge clk);
    stop_try = 1'b0;
    wait_try = 1'b0;
    g = mode_grant;
    ill = ill_rst_req;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic g, ill;
    int pulses;

    // table walk over the access filter
    for (int i = 0; i < 8; i++) begin
      do_reset();
      bus_write({1'b0, FILT_TAB[i][2], 6'b0});
      sec_on = FILT_TAB[i][3];
      acc_is_fetch = FILT_TAB[i][1];
      #1;
      check(FILT_TAB[i][3] ? (FILT_TAB[i][2] ? "R8" : "R7") : "R6",
            {7'b0, acc_ok}, {7'b0, FILT_TAB[i][0]});
    end
    sec_on = 1'b0;
    acc_is_fetch = 1'b0;

    // reset state
    do_reset();
    check("R1", rd_data, 8'h1C);
    check("R11", {6'b0, wdog_sel}, 8'h03);
    check("R1", {6'b0, mode_grant, ill_rst_req}, 8'h00);

    // reset value: wait enabled, stop disabled
    attempt(1'b0, g, ill);
    check("R9", {6'b0, g, ill}, 8'h02);
    attempt(1'b1, g, ill);
    check("R9", {6'b0, g, ill}, 8'h00);

    // first write, then locked writes
    bus_write(8'hFF);
    check("R2", rd_data, 8'h7C);
    check("R5", {rd_data[7], rd_data[1:0]}, 8'h00);
    bus_write(8'h00);
    check("R3", rd_data, 8'h6C);
    check("R4", {7'b0, rd_data[4]}, 8'h00);
    check("R11", {6'b0, wdog_sel}, 8'h03);
    bus_write(8'h10);
    check("R4", rd_data, 8'h7C);
    attempt(1'b1, g, ill);
    check("R9", {6'b0, g, ill}, 8'h02);

    // both modes disabled: illegal reset path
    do_reset();
    bus_write(8'h04);
    check("R2", rd_data, 8'h04);
    check("R11", {6'b0, wdog_sel}, 8'h01);
    attempt(1'b1, g, ill);
    check("R10", {6'b0, g, ill}, 8'h01);
    attempt(1'b0, g, ill);
    check("R9", {6'b0, g, ill}, 8'h00);
    ill_rst_dis = 1'b1;
    attempt(1'b1, g, ill);
    check("R10", {6'b0, g, ill}, 8'h00);
    ill_rst_dis = 1'b0;

    // held stop attempt gives one pulse
    pulses = 0;
    @(negedge clk);
    stop_try = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (ill_rst_req) pulses++;
    end
    stop_try = 1'b0;
    @(negedge clk);
    if (ill_rst_req) pulses++;
    check("R10", pulses[7:0], 8'h01);

    // locked write changes only wait enable
    bus_write(8'h38);
    check("R3", rd_data, 8'h14);

    // reset reopens the lock
    do_reset();
    bus_write(8'h48);
    check("R3", rd_data, 8'h48);
    check("R11", {6'b0, wdog_sel}, 8'h02);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule